// File: doc/BRIEF.md
# PCI Bus Parity Generator and Checker

This block produces and checks the even parity bits of a 64-bit PCI bus. While the agent drives the bus, it computes one parity bit for the lower address/data half with its four byte-enable lines and one for the upper half with its four byte-enable lines. Each bit is presented one clock after the values it covers. While another agent drives the bus, it recomputes the same bits and compares them with the received parity lines one clock after the covered phase.

A mismatch in a data phase is reported as a one-clock active-low data parity error pulse. A mismatch in the lower half during an address phase is reported as a one-clock active-low system error pulse. Each pulse is gated by the command register enables in force during the check cycle. Two sticky status flags record detected parity errors and signalled system errors until they are cleared.

Top module: `pci_parity_unit`

## Requirements
- R1: While reset is high, and until the first clock edge after it is released, `par_o`, `par64_o`, `par_oe_o`, `det_perr_o` and `sig_serr_o` are 0, and `perr_n_o` and `serr_n_o` are 1.
- R2: In the cycle after `ad_i`/`cbe_i` are presented, `par_o` equals the XOR of `ad_i[31:0]` and `cbe_i[3:0]`, and `par64_o` equals the XOR of `ad_i[63:32]` and `cbe_i[7:4]`. This makes each half even together with its parity bit.
- R3: `par_oe_o` equals the value `drive_en_i` had one cycle earlier.
- R4: A checked data phase is a cycle with `phase_i` = 2'b10 and `drive_en_i` = 0. If, in the following cycle, `par_i` or `par64_i` breaks even parity for its half and `per_en_i` is 1, then `perr_n_o` is 0 for exactly the cycle after that, which is two cycles after the data phase.
- R5: If `per_en_i` is 0 in the check cycle of a failing data phase, `perr_n_o` stays 1.
- R6: A checked address phase is a cycle with `phase_i` = 2'b01 and `drive_en_i` = 0. A lower-half mismatch on `par_i` in the next cycle, with `per_en_i` and `serr_en_i` both 1, drives `serr_n_o` to 0 for one cycle two cycles after the address phase, and `perr_n_o` stays 1. An upper-half mismatch in an address phase is ignored.
- R7: If either `per_en_i` or `serr_en_i` is 0 in the check cycle of a failing address phase, `serr_n_o` stays 1.
- R8: Any reported-or-not mismatch of a checked phase sets `det_perr_o`, visible two cycles after the phase, whatever the enables are. Each issued system error pulse sets `sig_serr_o` at the same time. Both flags hold until a cycle with `sts_clr_i` = 1 clears them, and a new set in that same cycle wins over the clear.
- R9: Cycles with `drive_en_i` = 1, or with `phase_i` equal to 2'b00 or 2'b11, are not checked. A wrong parity after such a cycle causes no pulse and sets no flag.
- R10: Received parity that keeps each half even produces no pulse and sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| ad_i | input | 64 | Address/data lines seen on the bus this cycle |
| cbe_i | input | 8 | Command/byte-enable lines (active-low values as on the bus) |
| phase_i | input | 2 | Phase type: 00 idle, 01 address, 10 data, 11 idle |
| drive_en_i | input | 1 | This agent drives AD and C/BE this cycle |
| par_i | input | 1 | Received lower-half parity (covers previous cycle) |
| par64_i | input | 1 | Received upper-half parity (covers previous cycle) |
| per_en_i | input | 1 | Parity error response enable |
| serr_en_i | input | 1 | System error enable |
| sts_clr_i | input | 1 | Clear both sticky status flags |
| par_o | output | 1 | Generated lower-half parity |
| par64_o | output | 1 | Generated upper-half parity |
| par_oe_o | output | 1 | Parity output enable, one cycle after drive enable |
| perr_n_o | output | 1 | Data parity error pulse, active low |
| serr_n_o | output | 1 | Address parity system error pulse, active low |
| det_perr_o | output | 1 | Sticky detected parity error flag |
| sig_serr_o | output | 1 | Sticky signalled system error flag |

## Verification
Generation is tried with all-zero, all-one, alternating and mixed bus words. These separate a correct half-by-half reduction from one that mixes the halves or drops the byte enables. Checking is tried with back-to-back phases that flip only the lower parity bit, only the upper one, or neither. This separates a data check that covers both halves from an address check that covers only the lower half, and confirms that the received bit is compared with the previous cycle's phase. Each enable is also cleared on its own during a failing phase, and a clear is issued together with a fresh error. This separates pulse gating from the ungated sticky status and shows which of clear and set has priority.

// File: rtl/pp_pkg.sv
package pp_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_ADDR = 2'b01,
    PH_DATA = 2'b10,
    PH_RSVD = 2'b11
  } phase_e;

  typedef struct packed {
    logic addr;
    logic data;
  } chk_t;
endpackage

// File: rtl/pp_lane_par.sv
module pp_lane_par #(
  parameter int LANE_W = 32,
  localparam int BE_W = LANE_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LANE_W-1:0] ad_i,
  input  logic [BE_W-1:0]   cbe_i,
  input  logic              par_rx_i,
  output logic              par_q_o,
  output logic              mism_o
);
  // One register serves both the driven parity and the reference for the
  // received bit: both cover the previous cycle's lane values.
  logic par_q;

  always_ff @(posedge clk) begin
    if (rst) par_q <= 1'b0;
    else     par_q <= ^{ad_i, cbe_i};
  end

  assign par_q_o = par_q;
  assign mism_o  = par_q ^ par_rx_i;
endmodule

// File: rtl/pp_err_rep.sv
module pp_err_rep
  import pp_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       phase_i,
  input  logic             drive_en_i,
  input  logic [LANES-1:0] mism_i,
  input  logic             per_en_i,
  input  logic             serr_en_i,
  input  logic             sts_clr_i,
  output logic             perr_n_o,
  output logic             serr_n_o,
  output logic             det_perr_o,
  output logic             sig_serr_o
);
  chk_t chk_q;
  logic data_fail, addr_fail, serr_fire;
  logic perr_n_q, serr_n_q, det_q, sig_q;

  // Phase captured with the lane parity; checked against the next cycle's bits
  always_ff @(posedge clk) begin
    if (rst) begin
      chk_q <= '0;
    end else begin
      chk_q.addr <= (phase_e'(phase_i) == PH_ADDR) && !drive_en_i;
      chk_q.data <= (phase_e'(phase_i) == PH_DATA) && !drive_en_i;
    end
  end

  // Address phases cover the lower half only; data phases cover every lane
  assign data_fail = chk_q.data && (|mism_i);
  assign addr_fail = chk_q.addr && mism_i[0];
  assign serr_fire = addr_fail && per_en_i && serr_en_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      perr_n_q <= 1'b1;
      serr_n_q <= 1'b1;
      det_q    <= 1'b0;
      sig_q    <= 1'b0;
    end else begin
      perr_n_q <= !(data_fail && per_en_i);
      serr_n_q <= !serr_fire;
      det_q    <= (data_fail || addr_fail) || (det_q && !sts_clr_i);
      sig_q    <= serr_fire || (sig_q && !sts_clr_i);
    end
  end

  assign perr_n_o   = perr_n_q;
  assign serr_n_o   = serr_n_q;
  assign det_perr_o = det_q;
  assign sig_serr_o = sig_q;

  // R4 R5
  perr_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !perr_n_q |-> ($past(per_en_i) && $past(chk_q.data)));

  // R6 R7
  serr_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !serr_n_q |-> ($past(per_en_i) && $past(serr_en_i) && $past(chk_q.addr) && perr_n_q));

  // R8
  pulse_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (!perr_n_q || !serr_n_q) |-> det_q);

  // R8
  det_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (det_q && !sts_clr_i) |=> det_q);

  // R8
  sig_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (sig_q && !sts_clr_i) |=> sig_q);

  // R9
  no_chk_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!chk_q.addr && !chk_q.data) |=> (perr_n_q && serr_n_q));
endmodule

// File: rtl/pci_parity_unit.sv
module pci_parity_unit #(
  parameter int LANES  = 2,
  parameter int LANE_W = 32,
  localparam int AD_W  = LANES * LANE_W,
  localparam int BE_W  = AD_W / 8,
  localparam int LBE_W = LANE_W / 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AD_W-1:0] ad_i,
  input  logic [BE_W-1:0] cbe_i,
  input  logic [1:0]      phase_i,
  input  logic            drive_en_i,
  input  logic            par_i,
  input  logic            par64_i,
  input  logic            per_en_i,
  input  logic            serr_en_i,
  input  logic            sts_clr_i,
  output logic            par_o,
  output logic            par64_o,
  output logic            par_oe_o,
  output logic            perr_n_o,
  output logic            serr_n_o,
  output logic            det_perr_o,
  output logic            sig_serr_o
);
  logic [LANES-1:0] par_rx, par_gen, mism;
  logic             oe_q;

  // Lane 0 takes the lower parity line, the top lane takes the upper one
  always_comb begin
    par_rx = '0;
    par_rx[0] = par_i;
    par_rx[LANES-1] = par64_i;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pp_lane_par #(.LANE_W(LANE_W)) u_lane (
      .clk      (clk),
      .rst      (rst),
      .ad_i     (ad_i[g*LANE_W +: LANE_W]),
      .cbe_i    (cbe_i[g*LBE_W +: LBE_W]),
      .par_rx_i (par_rx[g]),
      .par_q_o  (par_gen[g]),
      .mism_o   (mism[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) oe_q <= 1'b0;
    else     oe_q <= drive_en_i;
  end

  pp_err_rep #(.LANES(LANES)) u_rep (
    .clk        (clk),
    .rst        (rst),
    .phase_i    (phase_i),
    .drive_en_i (drive_en_i),
    .mism_i     (mism),
    .per_en_i   (per_en_i),
    .serr_en_i  (serr_en_i),
    .sts_clr_i  (sts_clr_i),
    .perr_n_o   (perr_n_o),
    .serr_n_o   (serr_n_o),
    .det_perr_o (det_perr_o),
    .sig_serr_o (sig_serr_o)
  );

  assign par_o    = par_gen[0];
  assign par64_o  = par_gen[LANES-1];
  assign par_oe_o = oe_q;

  // R2
  par_even_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((^{$past(ad_i[LANE_W-1:0]), $past(cbe_i[LBE_W-1:0]), par_o}) == 1'b0));

  // R3
  oe_follow_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(par_oe_o) |-> $past(drive_en_i));
endmodule

// File: tb/tb_pci_parity_unit.sv
module tb_pci_parity_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] ad_i = '0;
  logic [7:0]  cbe_i = '0;
  logic [1:0]  phase_i = '0;
  logic        drive_en_i = 1'b0, par_i = 1'b0, par64_i = 1'b0;
  logic        per_en_i = 1'b0, serr_en_i = 1'b0, sts_clr_i = 1'b0;
  logic        par_o, par64_o, par_oe_o, perr_n_o, serr_n_o, det_perr_o, sig_serr_o;

  always #5 clk = ~clk;

  pci_parity_unit dut (
    .clk(clk), .rst(rst), .ad_i(ad_i), .cbe_i(cbe_i), .phase_i(phase_i),
    .drive_en_i(drive_en_i), .par_i(par_i), .par64_i(par64_i),
    .per_en_i(per_en_i), .serr_en_i(serr_en_i), .sts_clr_i(sts_clr_i),
    .par_o(par_o), .par64_o(par64_o), .par_oe_o(par_oe_o),
    .perr_n_o(perr_n_o), .serr_n_o(serr_n_o),
    .det_perr_o(det_perr_o), .sig_serr_o(sig_serr_o)
  );

  typedef struct {
    logic  par, par64, oe, perr_n, serr_n, det, sig;
    string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  // reference state
  logic pv_lo = 0, pv_hi = 0, pv_addr = 0, pv_data = 0, m_det = 0, m_sig = 0;

  localparam logic [1:0] IDL = 2'b00, ADR = 2'b01, DAT = 2'b10, RSV = 2'b11;

  task automatic chk(input logic act, input logic exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // elo/ehi flip the received bits covering the previous step's phase;
  // per/sen/clr apply to this cycle, which is that phase's check cycle.
  task automatic step(input logic [63:0] ad, input logic [7:0] cbe, input logic [1:0] ph,
                      input logic drv, input logic elo, input logic ehi,
                      input logic per, input logic sen, input logic clr, input string tag);
    exp_t e;
    logic dfail, afail, fire;
    @(negedge clk);
    ad_i = ad; cbe_i = cbe; phase_i = ph; drive_en_i = drv;
    par_i = pv_lo ^ elo; par64_i = pv_hi ^ ehi;
    per_en_i = per; serr_en_i = sen; sts_clr_i = clr;
    dfail = pv_data && (elo || ehi);
    afail = pv_addr && elo;
    fire  = afail && per && sen;
    m_det = dfail || afail || (m_det && !clr);
    m_sig = fire || (m_sig && !clr);
    e.par = ^{ad[31:0], cbe[3:0]};
    e.par64 = ^{ad[63:32], cbe[7:4]};
    e.oe = drv;
    e.perr_n = !(dfail && per);
    e.serr_n = !fire;
    e.det = m_det;
    e.sig = m_sig;
    e.tag = tag;
    q.push_back(e);
    pv_lo = e.par; pv_hi = e.par64;
    pv_addr = (ph == ADR) && !drv;
    pv_data = (ph == DAT) && !drv;
  endtask

  // monitor / scoreboard
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() != 0) begin
        e = q.pop_front();
        chk(par_o,      e.par,    "R2", "par_o");
        chk(par64_o,    e.par64,  "R2", "par64_o");
        chk(par_oe_o,   e.oe,     "R3", "par_oe_o");
        chk(perr_n_o,   e.perr_n, e.tag, "perr_n_o");
        chk(serr_n_o,   e.serr_n, e.tag, "serr_n_o");
        chk(det_perr_o, e.det,    "R8", "det_perr_o");
        chk(sig_serr_o, e.sig,    "R8", "sig_serr_o");
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    chk(par_o, 1'b0, "R1", "par_o");
    chk(par64_o, 1'b0, "R1", "par64_o");
    chk(par_oe_o, 1'b0, "R1", "par_oe_o");
    chk(perr_n_o, 1'b1, "R1", "perr_n_o");
    chk(serr_n_o, 1'b1, "R1", "serr_n_o");
    chk(det_perr_o, 1'b0, "R1", "det_perr_o");
    chk(sig_serr_o, 1'b0, "R1", "sig_serr_o");
    @(negedge clk);
    rst = 1'b0;

    // R2 R3: generation with several bus words while driving
    step(64'h0, 8'h00, DAT, 1, 0, 0, 1, 1, 0, "R2");
    step(64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, DAT, 1, 0, 0, 1, 1, 0, "R2");
    step(64'hAAAA_5555_0F0F_F0F0, 8'h3C, DAT, 1, 0, 0, 1, 1, 0, "R2");
    step(64'h0000_0001_8000_0000, 8'h1E, ADR, 1, 0, 0, 1, 1, 0, "R2");
    step(64'h1234_5678_9ABC_DEF0, 8'hA7, IDL, 0, 0, 0, 1, 1, 0, "R3");

    // R10: received parity correct, back-to-back checked phases
    step(64'hDEAD_BEEF_0000_0007, 8'h0E, ADR, 0, 0, 0, 1, 1, 0, "R10");
    step(64'h0102_0304_0506_0708, 8'hF0, DAT, 0, 0, 0, 1, 1, 0, "R10");
    step(64'hFFFF_0000_FFFF_0001, 8'h00, DAT, 0, 0, 0, 1, 1, 0, "R10");

    // R4: lower-half then upper-half data mismatch (flip covers previous phase)
    step(64'h0000_0000_0000_0003, 8'h0F, DAT, 0, 0, 0, 1, 1, 0, "R4");
    step(64'h7777_1111_2222_3333, 8'h55, DAT, 0, 1, 0, 1, 1, 0, "R4");
    step(64'h0, 8'h00, IDL, 0, 0, 1, 1, 1, 0, "R4");
    step(64'h0, 8'h00, IDL, 0, 0, 0, 1, 1, 0, "R4");

    // R8: clear the sticky flag
    step(64'h0, 8'h00, IDL, 0, 0, 0, 1, 1, 1, "R8");
    step(64'h0, 8'h00, IDL, 0, 0, 0, 1, 1, 0, "R8");

    // R5: data mismatch with response disabled sets flag only
    step(64'h0000_00FF_0000_0F00, 8'h81, DAT, 0, 0, 0, 1, 1, 0, "R5");
    step(64'h0, 8'h00, IDL, 0, 1, 1, 0, 1, 0, "R5");
    step(64'h0, 8'h00, IDL, 0, 0, 0, 1, 1, 1, "R5");

    // R6: address mismatch lower half raises system error, no data error
    step(64'h0000_0000_4000_1000, 8'h06, ADR, 0, 0, 0, 1, 1, 0, "R6");
    step(64'h0, 8'h00, IDL, 0, 1, 0, 1, 1, 0, "R6");
    // R6: upper-half mismatch in address phase ignored
    step(64'h0000_0000_4000_2000, 8'h07, ADR, 0, 0, 0, 1, 1, 1, "R6");
    step(64'h0, 8'h00, IDL, 0, 0, 1, 1, 1, 0, "R6");
    step(64'h0, 8'h00, IDL, 0, 0, 0, 1, 1, 0, "R6");

    // R7: system error gated by each enable
    step(64'h0000_0000_0000_1234, 8'h02, ADR, 0, 0, 0, 1, 1, 0, "R7");
    step(64'h0, 8'h00, IDL, 0, 1, 0, 1, 0, 0, "R7");
    step(64'h0000_0000_0000_5678, 8'h03, ADR, 0, 0, 0, 1, 1, 1, "R7");
    step(64'h0, 8'h00, IDL, 0, 1, 0, 0, 1, 0, "R7");
    step(64'h0, 8'h00, IDL, 0, 0, 0, 1, 1, 1, "R7");

    // R9: driven data phase and idle/reserved phases are not checked
    step(64'h0000_0000_0000_0042, 8'h00, DAT, 1, 0, 0, 1, 1, 0, "R9");
    step(64'h0000_0000_0000_0043, 8'h00, IDL, 0, 1, 1, 1, 1, 0, "R9");
    step(64'h0000_0000_0000_0044, 8'h00, RSV, 0, 1, 1, 1, 1, 0, "R9");
    step(64'h0000_0000_0000_0045, 8'h00, ADR, 1, 1, 1, 1, 1, 0, "R9");
    step(64'h0, 8'h00, IDL, 0, 1, 1, 1, 1, 0, "R9");

    // R8: new error in the same cycle as a clear wins
    step(64'h0000_0000_0000_0100, 8'h09, ADR, 0, 0, 0, 1, 1, 0, "R8");
    step(64'h0, 8'h00, IDL, 0, 1, 0, 1, 1, 0, "R8");
    step(64'h0000_0000_0000_0200, 8'h08, ADR, 0, 0, 0, 1, 1, 0, "R8");
    step(64'h0, 8'h00, IDL, 0, 1, 0, 1, 1, 1, "R8");
    step(64'h0, 8'h00, IDL, 0, 0, 0, 1, 1, 0, "R8");
    step(64'h0, 8'h00, IDL, 0, 0, 0, 1, 1, 1, "R8");
    step(64'h0, 8'h00, IDL, 0, 0, 0, 1, 1, 0, "R8");

    repeat (3) @(posedge clk);
    #3;
    finish_run();
  end
endmodule